// File: doc/BRIEF.md
# Disk Controller Command Decoder and Status Multiplexer

This block sits behind the command window of a floppy disk controller. A read cycle whose address bits 9:8 are both set carries two fields in its low address byte. Bits 3:0 name a command. Bits 7:4 choose which status byte comes back. The block runs the command first. It then returns the chosen status byte, built from the state as it stands after the command, one cycle later with `rsp_valid` high.

The block holds the motor-on, sector-flag, index and interrupt-arm state. Sector timing has no time base. Software polls with the no-op command, and each no-op on the selected drive moves that drive's own wait counter forward. Fixed counts along that counter open the sector window, raise read-enable and body, and at the end of a sector raise the sector flag and step the sector number. A four-state phase machine tracks the shared window, read-enable and body flags. Its states are PH_GAP (none set), PH_WINDOW (window only), PH_BODY_EARLY (read-enable and body without window) and PH_BODY (all three). A window event moves PH_GAP to PH_WINDOW and PH_BODY_EARLY to PH_BODY. A body event moves PH_GAP to PH_BODY_EARLY and PH_WINDOW to PH_BODY. A sector event returns every state to PH_GAP. PH_BODY_EARLY is reached only when the drive selection changes part way through a sector.

When the data-read select is used, the block raises a one-cycle hand-off pulse for the transfer block and returns zero. The reset-sector-flag command also pulses `xfer_clr`, which clears the transfer block's byte counter.

Top module: `disk_cmd_stat`

## Requirements
- R1: During and right after reset, `rsp_valid`, `rd_data`, `xfer_clr`, `data_sel`, `motor_on` and `irq_armed` are all 0. Every wait count, every sector number and every flag starts at 0.
- R2: A cycle acts only when `cyc_valid` is high and `cyc_addr[9:8]` is 2'b11. Its response appears on the next cycle with `rsp_valid` high. Any other cycle changes no state and gives no response.
- R3: Every status byte has the sector flag in bit 7, index in bit 6, double density (always 1) in bit 5 and motor-on in bit 4. Select values 0 and 5 to 15 return these four bits with the low nibble at 0.
- R4: Select 1 returns, in the low nibble, window in bit 3, read-enable in bit 2, a spare 0 in bit 1 and body in bit 0.
- R5: Select 2 returns, in the low nibble, `write_active` in bit 3, a spare 0 in bit 2, `write_prot` in bit 1 and `track_zero` in bit 0. All three inputs are sampled with the cycle.
- R6: Select 3 returns the selected drive's sector number in the low nibble, taken after the command has run.
- R7: Select 4 returns 0x00 and pulses `data_sel` together with `rsp_valid`.
- R8: Command 0 (no-op) adds one to the selected drive's wait count. Reaching 2 sets window. Reaching 3 sets read-enable and body.
- R9: When a no-op brings the count to 10, the sector flag is set, window, read-enable and body are cleared, the count returns to 0 and the sector number advances.
- R10: Advancing from sector 9 wraps to 0 and sets index. Every other advance clears index.
- R11: Command 1 clears the sector flag and pulses `xfer_clr` together with `rsp_valid`.
- R12: Command 5 turns the motor on and command 7 turns it off. Command 3 arms the interrupt and command 2 disarms it. Commands 4, 6 and 8 to 15 change nothing.
- R13: A drive's wait count and sector number move only on no-ops issued while that drive is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_valid | input | 1 | A controller read cycle is present this clock |
| cyc_addr | input | 10 | Cycle address: [9:8] window, [7:4] status select, [3:0] command |
| drive_sel | input | 2 | Index of the currently selected drive |
| write_active | input | 1 | A write is in progress (B-status bit 3) |
| write_prot | input | 1 | The selected disk is write protected (B-status bit 1) |
| track_zero | input | 1 | The selected drive is at track zero (B-status bit 0) |
| rd_data | output | 8 | Returned status byte |
| rsp_valid | output | 1 | `rd_data` holds a response this cycle |
| xfer_clr | output | 1 | Pulse: clear the transfer block's byte counter |
| data_sel | output | 1 | Pulse: data-read select handed to the transfer block |
| motor_on | output | 1 | Motor-on state |
| irq_armed | output | 1 | Interrupt-arm state |

## Verification
Each accepted cycle has exactly one result: the status byte and its two pulses, due on the clock after the strobe. For each cycle the driver pushes the result predicted by a requirement-level model into a queue. The monitor samples on the falling edge after that clock and pops one item for each `rsp_valid` it sees. An empty queue with `rsp_valid` high is a failure, as is anything left in the queue at the end. The level outputs `motor_on` and `irq_armed` change on the same clock, so they are sampled on the falling edge that ends the strobe. Ignored cycles are checked by confirming that no response follows and that the next wait-count and sector results continue as if the cycle never happened.

// File: rtl/disk_cmd_pkg.sv
package disk_cmd_pkg;

    localparam logic [1:0] WINDOW_ID     = 2'b11;

    localparam logic [3:0] CMD_NOP       = 4'd0;
    localparam logic [3:0] CMD_CLR_SF    = 4'd1;
    localparam logic [3:0] CMD_IRQ_OFF   = 4'd2;
    localparam logic [3:0] CMD_IRQ_ON    = 4'd3;
    localparam logic [3:0] CMD_MOTOR_ON  = 4'd5;
    localparam logic [3:0] CMD_RESET     = 4'd7;

    localparam logic [3:0] SEL_A         = 4'd1;
    localparam logic [3:0] SEL_B         = 4'd2;
    localparam logic [3:0] SEL_C         = 4'd3;
    localparam logic [3:0] SEL_DATA      = 4'd4;

    typedef enum logic [1:0] {
        PH_GAP        = 2'd0,
        PH_WINDOW     = 2'd1,
        PH_BODY_EARLY = 2'd2,
        PH_BODY       = 2'd3
    } phase_e;

endpackage

// File: rtl/disk_sector_timer.sv
module disk_sector_timer #(
    parameter int WAIT_LEN = 10,
    parameter int WIN_AT   = 2,
    parameter int BODY_AT  = 3,
    parameter int SECTORS  = 10,
    localparam int CNT_W   = $clog2(WAIT_LEN + 1),
    localparam int SEC_W   = $clog2(SECTORS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic             win_evt,
    output logic             body_evt,
    output logic             sect_evt,
    output logic             wrap_evt,
    output logic [SEC_W-1:0] sector_d
);

    logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
    logic [SEC_W-1:0] sector_q;

    always_comb begin
        cnt_inc  = cnt_q + 1'b1;
        win_evt  = tick && (cnt_inc == CNT_W'(WIN_AT));
        body_evt = tick && (cnt_inc == CNT_W'(BODY_AT));
        sect_evt = tick && (cnt_inc == CNT_W'(WAIT_LEN));
        wrap_evt = sect_evt && (sector_q == SEC_W'(SECTORS - 1));
        cnt_d    = cnt_q;
        sector_d = sector_q;
        if (tick) begin
            cnt_d = sect_evt ? '0 : cnt_inc;
        end
        if (sect_evt) begin
            sector_d = wrap_evt ? '0 : sector_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            sector_q <= '0;
        end else begin
            cnt_q    <= cnt_d;
            sector_q <= sector_d;
        end
    end

endmodule

// File: rtl/disk_phase_fsm.sv
module disk_phase_fsm
    import disk_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic win_evt,
    input  logic body_evt,
    input  logic sect_evt,
    output logic win_d,
    output logic rden_d,
    output logic body_d
);

    phase_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (sect_evt) begin
            state_d = PH_GAP;
        end else if (win_evt) begin
            unique case (state_q)
                PH_GAP:        state_d = PH_WINDOW;
                PH_BODY_EARLY: state_d = PH_BODY;
                PH_WINDOW:     state_d = PH_WINDOW;
                PH_BODY:       state_d = PH_BODY;
            endcase
        end else if (body_evt) begin
            unique case (state_q)
                PH_GAP:        state_d = PH_BODY_EARLY;
                PH_WINDOW:     state_d = PH_BODY;
                PH_BODY_EARLY: state_d = PH_BODY_EARLY;
                PH_BODY:       state_d = PH_BODY;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_GAP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        win_d  = 1'b0;
        rden_d = 1'b0;
        body_d = 1'b0;
        unique case (state_d)
            PH_GAP:        ;
            PH_WINDOW:     win_d = 1'b1;
            PH_BODY_EARLY: begin
                rden_d = 1'b1;
                body_d = 1'b1;
            end
            PH_BODY:       begin
                win_d  = 1'b1;
                rden_d = 1'b1;
                body_d = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/disk_stat_mux.sv
module disk_stat_mux
    import disk_cmd_pkg::*;
(
    input  logic [3:0] sel,
    input  logic       sf,
    input  logic       ix,
    input  logic       mo,
    input  logic       win,
    input  logic       rden,
    input  logic       body,
    input  logic       wr,
    input  logic       wp,
    input  logic       t0,
    input  logic [3:0] sector,
    output logic [7:0] stat_byte,
    output logic       is_data
);

    logic [3:0] upper;

    always_comb begin
        upper   = {sf, ix, 1'b1, mo};
        is_data = 1'b0;
        case (sel)
            SEL_A:    stat_byte = {upper, win, rden, 1'b0, body};
            SEL_B:    stat_byte = {upper, wr, 1'b0, wp, t0};
            SEL_C:    stat_byte = {upper, sector};
            SEL_DATA: begin
                stat_byte = 8'h00;
                is_data   = 1'b1;
            end
            default:  stat_byte = {upper, 4'h0};
        endcase
    end

endmodule

// File: rtl/disk_cmd_stat.sv
module disk_cmd_stat
    import disk_cmd_pkg::*;
#(
    parameter int NUM_DRIVES = 4,
    parameter int WAIT_LEN   = 10,
    parameter int WIN_AT     = 2,
    parameter int BODY_AT    = 3,
    parameter int SECTORS    = 10,
    localparam int DRV_W     = $clog2(NUM_DRIVES),
    localparam int SEC_W     = $clog2(SECTORS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_valid,
    input  logic [9:0]       cyc_addr,
    input  logic [DRV_W-1:0] drive_sel,
    input  logic             write_active,
    input  logic             write_prot,
    input  logic             track_zero,
    output logic [7:0]       rd_data,
    output logic             rsp_valid,
    output logic             xfer_clr,
    output logic             data_sel,
    output logic             motor_on,
    output logic             irq_armed
);

    logic       hit, nop_hit, clr_d;
    logic [3:0] cmd, sel;

    assign hit     = cyc_valid && (cyc_addr[9:8] == WINDOW_ID);
    assign cmd     = cyc_addr[3:0];
    assign sel     = cyc_addr[7:4];
    assign nop_hit = hit && (cmd == CMD_NOP);

    logic             win_a  [NUM_DRIVES];
    logic             body_a [NUM_DRIVES];
    logic             sect_a [NUM_DRIVES];
    logic             wrap_a [NUM_DRIVES];
    logic [SEC_W-1:0] sec_a  [NUM_DRIVES];

    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drive
        disk_sector_timer #(
            .WAIT_LEN (WAIT_LEN),
            .WIN_AT   (WIN_AT),
            .BODY_AT  (BODY_AT),
            .SECTORS  (SECTORS)
        ) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (nop_hit && (drive_sel == DRV_W'(d))),
            .win_evt  (win_a[d]),
            .body_evt (body_a[d]),
            .sect_evt (sect_a[d]),
            .wrap_evt (wrap_a[d]),
            .sector_d (sec_a[d])
        );
    end

    logic win_s, body_s, sect_s, wrap_s;
    logic [3:0] sector_s;

    assign win_s    = win_a[drive_sel];
    assign body_s   = body_a[drive_sel];
    assign sect_s   = sect_a[drive_sel];
    assign wrap_s   = wrap_a[drive_sel];
    assign sector_s = 4'(sec_a[drive_sel]);

    logic win_d, rden_d, body_d;

    disk_phase_fsm u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .win_evt  (win_s),
        .body_evt (body_s),
        .sect_evt (sect_s),
        .win_d    (win_d),
        .rden_d   (rden_d),
        .body_d   (body_d)
    );

    logic sf_q, ix_q, mo_q, irq_q;
    logic sf_d, ix_d, mo_d, irq_d;

    always_comb begin
        sf_d  = sf_q;
        ix_d  = ix_q;
        mo_d  = mo_q;
        irq_d = irq_q;
        clr_d = 1'b0;
        if (hit) begin
            case (cmd)
                CMD_CLR_SF:   begin
                    sf_d  = 1'b0;
                    clr_d = 1'b1;
                end
                CMD_IRQ_OFF:  irq_d = 1'b0;
                CMD_IRQ_ON:   irq_d = 1'b1;
                CMD_MOTOR_ON: mo_d  = 1'b1;
                CMD_RESET:    mo_d  = 1'b0;
                default:      ;
            endcase
        end
        if (sect_s) begin
            sf_d = 1'b1;
            ix_d = wrap_s;
        end
    end

    logic [7:0] stat_byte;
    logic       is_data;

    disk_stat_mux u_mux (
        .sel       (sel),
        .sf        (sf_d),
        .ix        (ix_d),
        .mo        (mo_d),
        .win       (win_d),
        .rden      (rden_d),
        .body      (body_d),
        .wr        (write_active),
        .wp        (write_prot),
        .t0        (track_zero),
        .sector    (sector_s),
        .stat_byte (stat_byte),
        .is_data   (is_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sf_q      <= 1'b0;
            ix_q      <= 1'b0;
            mo_q      <= 1'b0;
            irq_q     <= 1'b0;
            rd_data   <= 8'h00;
            rsp_valid <= 1'b0;
            xfer_clr  <= 1'b0;
            data_sel  <= 1'b0;
        end else begin
            sf_q      <= sf_d;
            ix_q      <= ix_d;
            mo_q      <= mo_d;
            irq_q     <= irq_d;
            rsp_valid <= hit;
            rd_data   <= hit ? stat_byte : 8'h00;
            xfer_clr  <= clr_d;
            data_sel  <= hit && is_data;
        end
    end

    assign motor_on  = mo_q;
    assign irq_armed = irq_q;

endmodule

// File: rtl/disk_cmd_stat_chk.sv
module disk_cmd_stat_chk #(
    parameter int SECTORS = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cyc_valid,
    input logic [9:0] cyc_addr,
    input logic [7:0] rd_data,
    input logic       rsp_valid,
    input logic       xfer_clr,
    input logic       data_sel,
    input logic       motor_on
);

    logic       live_q, hit_q;
    logic [3:0] sel_q, cmd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live_q <= 1'b0;
            hit_q  <= 1'b0;
            sel_q  <= 4'h0;
            cmd_q  <= 4'h0;
        end else begin
            live_q <= 1'b1;
            hit_q  <= cyc_valid && (cyc_addr[9:8] == 2'b11);
            sel_q  <= cyc_addr[7:4];
            cmd_q  <= cyc_addr[3:0];
        end
    end

    // R2
    rsp_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (rsp_valid == hit_q));

    // R3
    dd_bit_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && rsp_valid && sel_q != 4'd4) |-> rd_data[5]);

    // R4
    a_spare_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && rsp_valid && sel_q == 4'd1) |-> !rd_data[1]);

    // R6
    c_sector_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && rsp_valid && sel_q == 4'd3) |-> (rd_data[3:0] < 4'(SECTORS)));

    // R7
    data_handoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && rsp_valid && sel_q == 4'd4) |-> (data_sel && rd_data == 8'h00));

    // R11
    clr_drops_sf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_clr |-> (rsp_valid && !rd_data[7]));

    // R12
    motor_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $rose(motor_on)) |-> (hit_q && cmd_q == 4'd5));

endmodule

bind disk_cmd_stat disk_cmd_stat_chk #(.SECTORS(SECTORS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_valid (cyc_valid),
    .cyc_addr  (cyc_addr),
    .rd_data   (rd_data),
    .rsp_valid (rsp_valid),
    .xfer_clr  (xfer_clr),
    .data_sel  (data_sel),
    .motor_on  (motor_on)
);

// File: tb/tb_disk_cmd_stat.sv
module tb_disk_cmd_stat;

    localparam int PERIOD = 10;
    localparam int NDRV   = 4;
    localparam int WAITN  = 10;
    localparam int NSEC   = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_valid = 1'b0;
    logic [9:0] cyc_addr = '0;
    logic [1:0] drive_sel = '0;
    logic       write_active = 1'b0;
    logic       write_prot = 1'b0;
    logic       track_zero = 1'b0;
    logic [7:0] rd_data;
    logic       rsp_valid, xfer_clr, data_sel, motor_on, irq_armed;

    always #(PERIOD/2) clk = ~clk;

    disk_cmd_stat dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cyc_valid    (cyc_valid),
        .cyc_addr     (cyc_addr),
        .drive_sel    (drive_sel),
        .write_active (write_active),
        .write_prot   (write_prot),
        .track_zero   (track_zero),
        .rd_data      (rd_data),
        .rsp_valid    (rsp_valid),
        .xfer_clr     (xfer_clr),
        .data_sel     (data_sel),
        .motor_on     (motor_on),
        .irq_armed    (irq_armed)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // reference model, written from the requirements
    int m_cnt [NDRV];
    int m_sec [NDRV];
    bit m_sf, m_ix, m_mo, m_irq, m_wi, m_re, m_bd;

    logic [9:0] exp_q [$];
    string      tag_q [$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // driver: predicts the response and issues one accepted cycle
    task automatic issue(input int drv, input logic [3:0] cmd, input logic [3:0] sel,
                         input bit wr, input bit wp, input bit t0, input string tag);
        logic [7:0] b;
        logic [3:0] up;
        bit clr;
        clr = 1'b0;
        case (cmd)
            4'd0: begin
                m_cnt[drv]++;
                if (m_cnt[drv] == 2) m_wi = 1'b1;
                if (m_cnt[drv] == 3) begin m_re = 1'b1; m_bd = 1'b1; end
                if (m_cnt[drv] == WAITN) begin
                    m_sf = 1'b1; m_wi = 1'b0; m_re = 1'b0; m_bd = 1'b0;
                    m_cnt[drv] = 0;
                    m_sec[drv]++;
                    if (m_sec[drv] >= NSEC) begin m_sec[drv] = 0; m_ix = 1'b1; end
                    else m_ix = 1'b0;
                end
            end
            4'd1: begin m_sf = 1'b0; clr = 1'b1; end
            4'd2: m_irq = 1'b0;
            4'd3: m_irq = 1'b1;
            4'd5: m_mo = 1'b1;
            4'd7: m_mo = 1'b0;
            default: ;
        endcase
        up = {m_sf, m_ix, 1'b1, m_mo};
        case (sel)
            4'd1: b = {up, m_wi, m_re, 1'b0, m_bd};
            4'd2: b = {up, wr, 1'b0, wp, t0};
            4'd3: b = {up, 4'(m_sec[drv])};
            4'd4: b = 8'h00;
            default: b = {up, 4'h0};
        endcase
        exp_q.push_back({clr, (sel == 4'd4), b});
        tag_q.push_back(tag);
        @(negedge clk);
        drive_sel    = 2'(drv);
        write_active = wr;
        write_prot   = wp;
        track_zero   = t0;
        cyc_addr     = {2'b11, sel, cmd};
        cyc_valid    = 1'b1;
        @(negedge clk);
        cyc_valid    = 1'b0;
    endtask

    // monitor: pops one prediction per response
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected response", int'(rd_data), 0);
            end else begin
                logic [9:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({xfer_clr, data_sel, rd_data} == e, t,
                      int'({xfer_clr, data_sel, rd_data}), int'(e));
            end
        end
    end

    initial begin
        for (int i = 0; i < NDRV; i++) begin m_cnt[i] = 0; m_sec[i] = 0; end
        {m_sf, m_ix, m_mo, m_irq, m_wi, m_re, m_bd} = '0;
        repeat (3) @(negedge clk);
        // R1 outputs held at zero during reset
        check(!rsp_valid && rd_data == 8'h00 && !xfer_clr && !data_sel, "R1 reset outputs",
              int'({rsp_valid, xfer_clr, data_sel, rd_data}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!motor_on && !irq_armed && !rsp_valid, "R1 after reset",
              int'({motor_on, irq_armed, rsp_valid}), 0);

        // R8 R9 one full sector on drive 0, A-status each step
        for (int k = 0; k < WAITN; k++) issue(0, 4'd0, 4'd1, 0, 0, 0, "R8/R9 nop A-status");
        // R6 sector after the event, no-effect command 4
        issue(0, 4'd4, 4'd3, 0, 0, 0, "R6 C-status sector");
        // R11 clear flag, with R5 B-status inputs
        issue(0, 4'd1, 4'd2, 1, 0, 1, "R11/R5 clear sf, B-status");
        issue(0, 4'd6, 4'd2, 0, 1, 0, "R5 B-status write protect");
        // R12 motor and interrupt control
        issue(0, 4'd5, 4'd1, 0, 0, 0, "R12 motor on");
        check(motor_on, "R12 motor_on level", int'(motor_on), 1);
        issue(0, 4'd3, 4'd0, 0, 0, 0, "R12/R3 arm, select 0");
        check(irq_armed, "R12 irq armed", int'(irq_armed), 1);
        issue(0, 4'd2, 4'd15, 0, 0, 0, "R12/R3 disarm, select 15");
        check(!irq_armed, "R12 irq disarmed", int'(irq_armed), 0);
        issue(0, 4'd9, 4'd7, 0, 0, 0, "R12/R3 command 9 no effect");
        // R7 data-read hand-off
        issue(0, 4'd4, 4'd4, 0, 0, 0, "R7 data select");

        // R13 drive 1 counts on its own, then drive 0 unchanged
        for (int k = 0; k < 3; k++) issue(1, 4'd0, 4'd1, 0, 0, 0, "R13 drive1 nop");
        issue(1, 4'd4, 4'd3, 0, 0, 0, "R13 drive1 sector");
        issue(0, 4'd4, 4'd3, 0, 0, 0, "R13 drive0 sector kept");

        // R2 a cycle outside the window is ignored
        @(negedge clk);
        drive_sel = 2'd0;
        cyc_addr  = {2'b10, 4'd1, 4'd0};
        cyc_valid = 1'b1;
        @(negedge clk);
        cyc_valid = 1'b0;
        check(!rsp_valid, "R2 ignored cycle", int'(rsp_valid), 0);
        @(negedge clk);
        check(!rsp_valid, "R2 ignored cycle later", int'(rsp_valid), 0);

        // R10 run drive 0 through the wrap and one sector beyond
        for (int k = 0; k < (NSEC - 1) * WAITN; k++)
            issue(0, 4'd0, 4'd3, 0, 0, 0, "R10 nop toward wrap");
        for (int k = 0; k < WAITN; k++)
            issue(0, 4'd0, 4'd3, 0, 0, 0, "R10 index clears after wrap");

        issue(0, 4'd7, 4'd1, 0, 0, 0, "R12 reset turns motor off");
        check(!motor_on, "R12 motor off", int'(motor_on), 0);

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R2 responses outstanding", exp_q.size(), 0);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule